// File: doc/BRIEF.md
# Mantissa-Exponent Baud Rate NCO

This block produces a symbol-rate strobe from a reference clock. A 28-bit phase accumulator advances once per enabled clock cycle. The step is built from an 8-bit mantissa with an implied leading one (256 + M), shifted left by a 4-bit exponent. The strobe rate is therefore fref × (256 + M) × 2^E / 2^28. Each increase of the exponent doubles both the rate and the rate resolution.

A one-cycle tick marks every wrap of the accumulator. A second strobe fires when the accumulator's top bit rises, which is half a period later, and can be used as a mid-symbol sample point. The mantissa input is one bit wider than the stored mantissa. This lets settings that round up to 256 be passed in directly: a normalising path turns them into mantissa 0 with the next exponent.

The enable freezes the phase. A synchronous clear zeroes it. New settings apply from the next clock edge without disturbing the accumulated phase.

Top module: `baud_nco_top`

## Requirements
- R1: While `rst_n` is low, `tick` and `mid_tick` are 0 and the phase is zero. The first tick after reset comes after exactly ceil(2^28 / step) enabled cycles.
- R2: On each rising clock edge with `en`=1 and `clr`=0, the phase grows by step = (256 + M) << E, modulo 2^28. `tick` is 1 for the cycle after an edge whose addition carried out of bit 27.
- R3: `tick` is never high in two consecutive cycles.
- R4: `mid_tick` is 1 for the cycle after an edge at which phase bit 27 changed from 0 to 1. It is never high in the same cycle as `tick`.
- R5: An edge with `en`=0 and `clr`=0 leaves the phase unchanged, and both strobes are 0 in the following cycle.
- R6: An edge with `clr`=1 zeroes the phase whatever `en` is, and both strobes are 0 in the following cycle.
- R7: A change of `mant` or `expo` is used from the next edge on, and the phase already accumulated is kept.
- R8: If bit 8 of the 9-bit `mant` input is set and `expo` is below 15, the block uses mantissa 0 and exponent `expo`+1. This applies to every value from 256 to 511.
- R9: If bit 8 of `mant` is set and `expo` is 15, the block uses mantissa 255 and exponent 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous phase clear, overrides `en` |
| en | input | 1 | Advance enable |
| mant | input | 9 | Mantissa; bit 8 set marks an over-range value to normalise |
| expo | input | 4 | Exponent |
| tick | output | 1 | One-cycle strobe on each phase wrap |
| mid_tick | output | 1 | One-cycle strobe when phase bit 27 rises |

## Verification
The bench builds the block with its defaults: a 28-bit phase, an 8-bit mantissa, a 4-bit exponent and the midpoint strobe present. Random settings are drawn from exponents 12 to 15. With these, periods fall between about 16 and 256 cycles, so thousands of wraps, midpoint strobes, enable gaps, clears and setting changes fit in a short run. Directed cases cover both normalisation branches and a mid-period exponent change, and they also count exact tick spacings.

// File: rtl/baud_nco_pkg.sv
package baud_nco_pkg;
   // width of (2^MW + M) << (2^EW - 1)
   function automatic int nco_step_w(input int mw, input int ew);
      return mw + 1 + (2 ** ew) - 1;
   endfunction
endpackage

// File: rtl/baud_nco_norm.sv
module baud_nco_norm #(
   parameter int MANT_W = 8,
   parameter int EXP_W  = 4
) (
   input  logic [MANT_W:0]   mant_raw,
   input  logic [EXP_W-1:0]  expo_raw,
   output logic [MANT_W-1:0] mant_n,
   output logic [EXP_W-1:0]  expo_n
);
   localparam logic [EXP_W-1:0] EXP_TOP = '1;

   always_comb begin
      if (!mant_raw[MANT_W]) begin
         mant_n = mant_raw[MANT_W-1:0];
         expo_n = expo_raw;
      end else if (expo_raw != EXP_TOP) begin
         mant_n = '0;
         expo_n = expo_raw + 1'b1;
      end else begin
         mant_n = '1;
         expo_n = EXP_TOP;
      end
   end
endmodule

// File: rtl/baud_nco_step.sv
module baud_nco_step #(
   parameter int MANT_W = 8,
   parameter int EXP_W  = 4,
   parameter int STEP_W = baud_nco_pkg::nco_step_w(MANT_W, EXP_W)
) (
   input  logic [MANT_W-1:0] mant_n,
   input  logic [EXP_W-1:0]  expo_n,
   output logic [STEP_W-1:0] step
);
   logic [STEP_W-1:0] base;

   always_comb begin
      base = '0;
      base[MANT_W:0] = {1'b1, mant_n};
      step = base << expo_n;
   end
endmodule

// File: rtl/baud_nco_acc.sv
module baud_nco_acc #(
   parameter int ACC_W  = 28,
   parameter int STEP_W = 24,
   parameter bit MID_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [STEP_W-1:0] step,
   output logic              tick,
   output logic              mid_tick
);
   localparam int MSB = ACC_W - 1;

   logic [ACC_W-1:0] phase_q;
   logic [ACC_W:0]   sum;
   logic             tick_q;

   always_comb sum = {1'b0, phase_q} + {{(ACC_W + 1 - STEP_W){1'b0}}, step};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         tick_q  <= 1'b0;
      end else if (clr) begin
         phase_q <= '0;
         tick_q  <= 1'b0;
      end else if (en) begin
         phase_q <= sum[ACC_W-1:0];
         tick_q  <= sum[ACC_W];
      end else begin
         tick_q  <= 1'b0;
      end
   end

   assign tick = tick_q;

   generate
      if (MID_EN) begin : g_mid
         logic mid_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        mid_q <= 1'b0;
            else if (clr)      mid_q <= 1'b0;
            else if (en)       mid_q <= !phase_q[MSB] && sum[MSB];
            else               mid_q <= 1'b0;
         end
         assign mid_tick = mid_q;

         AST_MID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            mid_tick |-> (phase_q[MSB] && !$past(phase_q[MSB]))) else $error("mid rise"); // R4
         AST_MID_APART: assert property (@(posedge clk) disable iff (!rst_n)
            !(mid_tick && tick_q)) else $error("mid with tick"); // R4
      end else begin : g_nomid
         assign mid_tick = 1'b0;
      end
   endgenerate

   AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |-> (!phase_q[MSB] && $past(phase_q[MSB]))) else $error("tick w/o wrap"); // R2
   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |=> !tick_q) else $error("double tick"); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> ($stable(phase_q) && !tick_q && !mid_tick)) else $error("idle moved"); // R5
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (phase_q == '0 && !tick_q && !mid_tick)) else $error("clear"); // R6
endmodule

// File: rtl/baud_nco_top.sv
module baud_nco_top #(
   parameter int ACC_W  = 28,
   parameter int MANT_W = 8,
   parameter int EXP_W  = 4,
   parameter bit MID_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [MANT_W:0]   mant,
   input  logic [EXP_W-1:0]  expo,
   output logic              tick,
   output logic              mid_tick
);
   localparam int STEP_W = baud_nco_pkg::nco_step_w(MANT_W, EXP_W);

   generate
      if (STEP_W > ACC_W - 1) begin : g_bad_width
         $error("step width %0d must stay below accumulator width %0d", STEP_W, ACC_W);
      end
      if (MANT_W < 1 || EXP_W < 1) begin : g_bad_field
         $error("mantissa and exponent need at least one bit");
      end
   endgenerate

   logic [MANT_W-1:0] mant_n;
   logic [EXP_W-1:0]  expo_n;
   logic [STEP_W-1:0] step;

   baud_nco_norm #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_norm (
      .mant_raw (mant),
      .expo_raw (expo),
      .mant_n   (mant_n),
      .expo_n   (expo_n)
   );

   baud_nco_step #(.MANT_W(MANT_W), .EXP_W(EXP_W), .STEP_W(STEP_W)) u_step (
      .mant_n (mant_n),
      .expo_n (expo_n),
      .step   (step)
   );

   baud_nco_acc #(.ACC_W(ACC_W), .STEP_W(STEP_W), .MID_EN(MID_EN)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .en       (en),
      .step     (step),
      .tick     (tick),
      .mid_tick (mid_tick)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      $rose(rst_n) |-> (!tick && !mid_tick)) else $error("reset strobes"); // R1
endmodule

// File: tb/tb_baud_nco_top.sv
module tb_baud_nco_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic       en = 1'b0;
   logic [8:0] mant = '0;
   logic [3:0] expo = '0;
   logic       tick, mid_tick;

   int n_chk = 0;
   int n_bad = 0;
   logic [27:0] m_acc = '0;
   logic        m_tick = 1'b0, m_mid = 1'b0;

   always #4 clk = ~clk;

   baud_nco_top dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
      .mant(mant), .expo(expo), .tick(tick), .mid_tick(mid_tick)
   );

   function automatic logic [31:0] step_f(input logic [8:0] m, input logic [3:0] e);
      logic [7:0] mm;
      logic [3:0] ee;
      if (!m[8])            begin mm = m[7:0]; ee = e; end
      else if (e != 4'hF)   begin mm = 8'd0;  ee = e + 4'd1; end
      else                  begin mm = 8'hFF; ee = 4'hF; end
      return (32'd256 + 32'(mm)) << ee;
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp_v, input string what);
      n_chk++;
      if (act !== exp_v) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp_v, $time);
      end
   endtask

   // apply current inputs for one edge, then compare at the following negedge
   task automatic cyc(input string tag);
      logic [28:0] s;
      if (clr) begin
         m_acc = '0; m_tick = 0; m_mid = 0;
      end else if (en) begin
         s = {1'b0, m_acc} + 29'(step_f(mant, expo));
         m_tick = s[28];
         m_mid  = !m_acc[27] && s[27];
         m_acc  = s[27:0];
      end else begin
         m_tick = 0; m_mid = 0;
      end
      @(posedge clk);
      @(negedge clk);
      chk(tag, tick, m_tick, "tick");
      chk(tag, mid_tick, m_mid, "mid_tick");
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cnt;
      void'($urandom(32'd4242));
      // R1: reset state
      mant = 9'd0; expo = 4'd15; en = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", tick, 1'b0, "tick in reset");
      chk("R1", mid_tick, 1'b0, "mid in reset");
      rst_n = 1'b1;
      // step 2^23 -> first wrap after exactly 32 cycles
      cnt = 0;
      for (int k = 1; k <= 64; k++) begin
         cyc("R1");
         if (tick) begin
            cnt++;
            if (cnt == 1) chk("R1", 1'b1, k == 32, "first tick at cycle 32");
         end
      end
      chk("R2", 1'b1, cnt == 2, "two ticks in 64 cycles");

      // R8: 256 with exponent 14 acts as M=0,E=15 (period 32)
      clr = 1'b1; cyc("R6"); clr = 1'b0;
      mant = 9'd256; expo = 4'd14; cnt = 0;
      for (int k = 1; k <= 64; k++) begin
         cyc("R8");
         if (tick) cnt++;
         if (k == 16) chk("R8", mid_tick, 1'b1, "mid at 16");
      end
      chk("R8", 1'b1, cnt == 2, "normalised period 32");
      mant = 9'd400; expo = 4'd13;
      repeat (80) cyc("R8");

      // R9: saturation at the top exponent
      clr = 1'b1; cyc("R6"); clr = 1'b0;
      mant = 9'd300; expo = 4'd15;
      repeat (100) cyc("R9");

      // R7: exponent change mid-period keeps phase
      clr = 1'b1; cyc("R6"); clr = 1'b0;
      mant = 9'd0; expo = 4'd15;
      repeat (10) cyc("R7");
      expo = 4'd14; cnt = 0;
      for (int k = 1; k <= 44; k++) begin
         cyc("R7");
         if (tick) chk("R7", 1'b1, k == 44, "tick after 44 half steps");
      end

      // R5: hold
      en = 1'b0;
      repeat (20) cyc("R5");
      en = 1'b1;
      repeat (40) cyc("R5");

      // R6: clear while disabled
      en = 1'b0; clr = 1'b1; cyc("R6"); clr = 1'b0; en = 1'b1;
      repeat (31) cyc("R6");
      cyc("R6");

      // random mix
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 99) < 3) begin
            mant = 9'($urandom_range(0, 511));
            expo = 4'($urandom_range(12, 15));
         end
         en  = ($urandom_range(0, 9) != 0);
         clr = ($urandom_range(0, 199) == 0);
         cyc("R2 R3 R4");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule